// File: doc/BRIEF.md
# Pin Edge Interrupt Front End

This block watches two 8-bit general-purpose input ports and turns chosen pin transitions into latched interrupt flags. Each pin has three control bits: a polarity bit that picks which transition counts, an enable bit, and a sticky flag. Every pin input is first brought into the clock domain through a two-stage synchronizer. The edge detector then looks at the synchronized level combined with the polarity bit.

Each port drives one interrupt request. The request is a registered OR, over that port's pins, of flag AND enable. Software uses a small register bus to read the synchronized levels and to read or write the polarity, enable and flag registers. The polarity bit feeds the same detector as the pin level. Rewriting the polarity bit can therefore raise a flag by itself. Whether it does depends on the current pin level.

The synchronizer flops clear to 0 on reset. A pin that is already high when reset is released is therefore seen as a rising transition.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every polarity, enable and flag register reads 0 and both interrupt requests are low.
- R2: With a pin's polarity bit at 0, a low-to-high pin change sets that pin's flag. The flag becomes visible 3 clock edges after the pin changes (two synchronizer stages plus one detector stage). A high-to-low change leaves the flag alone.
- R3: With a pin's polarity bit at 1, a high-to-low pin change sets that pin's flag with the same 3-edge latency. A low-to-high change leaves the flag alone.
- R4: Writing a polarity bit from 0 to 1 sets the pin's flag on the next clock edge if the synchronized pin is low. If the pin is high, the flag is unchanged.
- R5: Writing a polarity bit from 1 to 0 sets the pin's flag on the next clock edge if the synchronized pin is high. If the pin is low, the flag is unchanged.
- R6: A flag is set whatever the enable bit is. A port's request goes high one clock edge after any pin on that port has both its flag and its enable bit at 1. It stays high until no such pin remains.
- R7: Writing 0 to a flag bit clears it. If a detected transition and a clearing write hit the same flag on the same edge, the flag ends up set.
- R8: The level register returns the pin value as it was two clock edges earlier.
- R9: The two ports are independent. A transition on one port's pin changes no flag and no request on the other port.
- R10: The register address is {port, sel}. Sel 0 is the level register, which is read-only; writes to it are ignored. Sel 1 is polarity, sel 2 is enable and sel 3 is flags. Bit i of each register belongs to pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | NPORTS*WIDTH (16) | Asynchronous pin inputs; port p occupies bits p*WIDTH upward |
| bus_we | input | 1 | Register write strobe, taken on the rising clock edge |
| bus_addr | input | clog2(NPORTS)+2 (3) | Register address {port, sel} |
| bus_wdata | input | WIDTH (8) | Write data |
| bus_rdata | output | WIDTH (8) | Read data, combinational from bus_addr |
| irq_o | output | NPORTS (2) | Per-port interrupt request |

## Verification
A stale detector register or a polarity bit that failed to update would show up as a flag at the ports. It appears either at a cycle where no transition was driven, or missing at the third edge after a real transition, or on the edge after a polarity write whose expected result depends on pin level and old polarity. A wrong enable or request path appears on irq_o exactly one edge after the flag or enable changes. The bench sweeps every pin, polarity and transition direction, and every old-polarity/level pair, on both ports. It samples exactly one cycle before and at the expected edge, so an off-by-one latency is also caught.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
// Package: shared register selector encoding for the pin edge interrupt block.
package gpio_irq_pkg;
    typedef enum logic [1:0] {
        REG_LEVEL = 2'd0,
        REG_POL   = 2'd1,
        REG_EN    = 2'd2,
        REG_FLAG  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
// gpio_sync: multi-stage flop chain that brings asynchronous pin levels
// into the clk domain. Assumes STAGES >= 1. All stages clear to 0 on reset.
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    // Shift the pin levels one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_port.sv
`timescale 1ns/1ps
// gpio_edge_port: per-port polarity, enable and flag registers plus the edge
// detector and the registered request. The detector looks for a rise of
// (level XOR polarity), which covers both pin edges and polarity rewrites.
// Assumes lvl_i is already synchronous to clk.
module gpio_edge_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic         pol_we_i,
    input  logic         en_we_i,
    input  logic         flag_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] pol_o,
    output logic [W-1:0] en_o,
    output logic [W-1:0] flag_o,
    output logic         irq_o
);
    logic [W-1:0] pol_q, en_q, flag_q, det_q;
    logic [W-1:0] det, hit;
    logic         irq_q;

    assign det = lvl_i ^ pol_q;
    assign hit = det & ~det_q;

    // Software-owned polarity and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= '0;
            en_q  <= '0;
        end else begin
            if (pol_we_i) pol_q <= wdata_i;
            if (en_we_i)  en_q  <= wdata_i;
        end
    end

    // Detector history and sticky flags; a detected hit overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q  <= '0;
            flag_q <= '0;
        end else begin
            det_q  <= det;
            flag_q <= (flag_we_i ? wdata_i : flag_q) | hit;
        end
    end

    // Registered port request from enabled flags.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flag_q & en_q);
    end

    assign pol_o  = pol_q;
    assign en_o   = en_q;
    assign flag_o = flag_q;
    assign irq_o  = irq_q;
endmodule

// File: rtl/gpio_edge_irq.sv
`timescale 1ns/1ps
// gpio_edge_irq: top of the pin edge interrupt front end. Instantiates one
// synchronizer and one edge/flag unit per port and decodes the register bus.
// Assumes NPORTS >= 2 so that the port field of the address is non-empty.
module gpio_edge_irq
    import gpio_irq_pkg::*;
#(
    parameter int NPORTS      = 2,
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int PW         = $clog2(NPORTS),
    localparam int ADDR_W     = PW + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORTS*WIDTH-1:0] pins_i,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [WIDTH-1:0]        bus_wdata,
    output logic [WIDTH-1:0]        bus_rdata,
    output logic [NPORTS-1:0]       irq_o
);
    reg_sel_e        rsel;
    logic [PW-1:0]   port_idx;
    logic [WIDTH-1:0] lvl_a  [NPORTS];
    logic [WIDTH-1:0] pol_a  [NPORTS];
    logic [WIDTH-1:0] en_a   [NPORTS];
    logic [WIDTH-1:0] flag_a [NPORTS];

    // Flattened views of the per-port state, for the bound checker.
    logic [NPORTS*WIDTH-1:0] lvl_w, pol_w, en_w, flag_w;

    assign rsel     = reg_sel_e'(bus_addr[1:0]);
    assign port_idx = bus_addr[ADDR_W-1:2];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic hit_port;
        assign hit_port = bus_we && (port_idx == PW'(p));

        gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
            .clk (clk),
            .rst_n (rst_n),
            .d_i (pins_i[p*WIDTH +: WIDTH]),
            .q_o (lvl_a[p])
        );

        gpio_edge_port #(.W(WIDTH)) edge_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl_i     (lvl_a[p]),
            .pol_we_i  (hit_port && rsel == REG_POL),
            .en_we_i   (hit_port && rsel == REG_EN),
            .flag_we_i (hit_port && rsel == REG_FLAG),
            .wdata_i   (bus_wdata),
            .pol_o     (pol_a[p]),
            .en_o      (en_a[p]),
            .flag_o    (flag_a[p]),
            .irq_o     (irq_o[p])
        );

        assign lvl_w [p*WIDTH +: WIDTH] = lvl_a[p];
        assign pol_w [p*WIDTH +: WIDTH] = pol_a[p];
        assign en_w  [p*WIDTH +: WIDTH] = en_a[p];
        assign flag_w[p*WIDTH +: WIDTH] = flag_a[p];
    end

    // Read multiplexer: selected register of the addressed port.
    always_comb begin
        bus_rdata = '0;
        if (int'(port_idx) < NPORTS) begin
            case (rsel)
                REG_LEVEL: bus_rdata = lvl_a[port_idx];
                REG_POL:   bus_rdata = pol_a[port_idx];
                REG_EN:    bus_rdata = en_a[port_idx];
                REG_FLAG:  bus_rdata = flag_a[port_idx];
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_edge_irq_chk.sv
`timescale 1ns/1ps
// gpio_edge_irq_chk: property checker bound to gpio_edge_irq. Observes the bus,
// the pins, the requests and the flattened per-port register state.
module gpio_edge_irq_chk #(
    parameter int NPORTS      = 2,
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NPORTS*WIDTH-1:0] pins_i,
    input logic                    bus_we,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [NPORTS-1:0]       irq_o,
    input logic [NPORTS*WIDTH-1:0] lvl_all,
    input logic [NPORTS*WIDTH-1:0] pol_all,
    input logic [NPORTS*WIDTH-1:0] en_all,
    input logic [NPORTS*WIDTH-1:0] flag_all
);
    logic [1:0] since_rst;

    // Count cycles since reset release, saturating, to gate history checks.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        p_pol_needs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (pol_all[p*WIDTH +: WIDTH] != $past(pol_all[p*WIDTH +: WIDTH]))
            |-> $past(bus_we && bus_addr == ADDR_W'(p*4 + 1)));

        p_en_needs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (en_all[p*WIDTH +: WIDTH] != $past(en_all[p*WIDTH +: WIDTH]))
            |-> $past(bus_we && bus_addr == ADDR_W'(p*4 + 2)));

        p_flag_clear_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (|($past(flag_all[p*WIDTH +: WIDTH]) & ~flag_all[p*WIDTH +: WIDTH]))
            |-> $past(bus_we && bus_addr == ADDR_W'(p*4 + 3)));

        p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[p] |-> $past(|flag_all[p*WIDTH +: WIDTH]));
    end

    if (SYNC_STAGES == 2) begin : g_sync_chk
        p_level_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd3) |-> (lvl_all == $past(pins_i, 2)));
    end
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
    .NPORTS(NPORTS), .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins_i   (pins_i),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .irq_o    (irq_o),
    .lvl_all  (lvl_w),
    .pol_all  (pol_w),
    .en_all   (en_w),
    .flag_all (flag_w)
);

// File: tb/gpio_edge_irq_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps every pin, polarity and direction on both ports, plus the
// polarity-rewrite cases, enable/request timing and clear/set collision.
module gpio_edge_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pins = '0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  irq_o;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    logic [7:0]  v;

    always #4 clk = ~clk;

    gpio_edge_irq dut_i (
        .clk (clk), .rst_n (rst_n), .pins_i (pins), .bus_we (bus_we),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .irq_o (irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Write at one posedge; returns at the following negedge.
    task automatic wr(input int p, input int r, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'(p*4 + r); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int p, input int r, output logic [7:0] o);
        bus_addr = 3'(p*4 + r);
        #1;
        o = bus_rdata;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int p = 0; p < 2; p++)
            for (int r = 1; r < 4; r++) begin
                rd(p, r, v); chk("R1 reg after reset", v, 0);
            end
        chk("R1 irq after reset", irq_o, 0);

        // R2/R3/R9: pin transition sweep
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 8; i++)
                for (int s = 0; s < 2; s++)
                    for (int rise = 0; rise < 2; rise++) begin
                        bit hit;
                        @(negedge clk);
                        pins[p*8 +: 8] = rise ? 8'h00 : 8'hFF;
                        repeat (4) @(negedge clk);
                        wr(p, 1, s ? 8'hFF : 8'h00);
                        repeat (2) @(negedge clk);
                        wr(0, 3, 8'h00);
                        wr(1, 3, 8'h00);
                        rd(p, 3, v); chk("R2 flags clear before edge", v, 0);
                        @(negedge clk);
                        pins[p*8 + i] = rise[0];
                        repeat (2) @(negedge clk);
                        rd(p, 3, v); chk("R2 no flag before third edge", v, 0);
                        @(negedge clk);
                        hit = (rise == 1 && s == 0) || (rise == 0 && s == 1);
                        rd(p, 3, v);
                        chk(s ? "R3 falling polarity flag" : "R2 rising polarity flag",
                            v, hit ? (1 << i) : 0);
                        rd(1 - p, 3, v); chk("R9 other port flag untouched", v, 0);
                    end

        // R4/R5: polarity rewrite sweep
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 8; i++)
                for (int old = 0; old < 2; old++)
                    for (int lvl = 0; lvl < 2; lvl++) begin
                        logic [7:0] pv;
                        @(negedge clk);
                        pins[p*8 +: 8] = 8'h00;
                        pins[p*8 + i] = lvl[0];
                        repeat (4) @(negedge clk);
                        pv = 8'h00; pv[i] = old[0];
                        wr(p, 1, pv);
                        repeat (2) @(negedge clk);
                        wr(p, 3, 8'h00);
                        rd(p, 3, v); chk("R4 flags clear before rewrite", v, 0);
                        pv[i] = ~old[0];
                        wr(p, 1, pv);
                        @(negedge clk);
                        rd(p, 3, v);
                        chk(old ? "R5 pol 1->0 rewrite" : "R4 pol 0->1 rewrite",
                            v, (old == lvl) ? (1 << i) : 0);
                    end

        // R6/R9: flag while disabled, then enable
        wr(0, 1, 8'h00); wr(1, 1, 8'h00); wr(0, 2, 8'h00); wr(1, 2, 8'h00);
        @(negedge clk);
        pins = '0;
        repeat (4) @(negedge clk);
        wr(0, 3, 8'h00); wr(1, 3, 8'h00);
        pins[8 + 5] = 1'b1;
        repeat (5) @(negedge clk);
        rd(1, 3, v); chk("R6 flag set while disabled", v, 8'h20);
        chk("R6 no irq while disabled", irq_o, 0);
        wr(1, 2, 8'h01);
        @(negedge clk);
        chk("R6 irq stays low for other enable", irq_o, 0);
        wr(1, 2, 8'h20);
        rd(1, 2, v); chk("R10 enable readback", v, 8'h20);
        chk("R6 irq not yet at enable edge", irq_o, 0);
        @(negedge clk);
        chk("R6 R9 irq only on port 1", irq_o, 2'b10);
        wr(1, 3, 8'h00);
        @(negedge clk);
        chk("R6 irq drops after clear", irq_o, 0);

        // R7: clear and hardware set on the same edge
        @(negedge clk);
        pins[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'(0*4 + 3); bus_wdata = 8'h00;
        @(negedge clk);
        bus_we = 1'b0;
        rd(0, 3, v); chk("R7 hardware set wins over clear", v, 8'h08);
        wr(0, 3, 8'h00);
        rd(0, 3, v); chk("R7 write 0 clears", v, 0);

        // R8: level register latency
        for (int k = 0; k < 16; k++) begin
            logic [15:0] prev, nxt;
            prev = pins;
            nxt  = 16'((k * 16'h3A5B) ^ (k << 9) ^ 16'h0F0F);
            @(negedge clk);
            pins = nxt;
            @(negedge clk);
            rd(k % 2, 0, v); chk("R8 level after one edge", v, prev[(k%2)*8 +: 8]);
            @(negedge clk);
            rd(k % 2, 0, v); chk("R8 level after two edges", v, nxt[(k%2)*8 +: 8]);
        end

        // R10: level register is read-only
        wr(0, 0, ~pins[7:0]);
        rd(0, 0, v); chk("R10 level write ignored", v, pins[7:0]);
        rd(0, 1, v); chk("R10 level write leaves polarity", v, 0);
        rd(0, 2, v); chk("R10 level write leaves enable", v, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule